// File: doc/BRIEF.md
# Timer Break and Main Output Enable Controller

This block owns the main output enable of a PWM timer's output stage. A fault (break) pin passes through an enable gate and a polarity selector. While the resulting break condition is present, the main enable is forced low without waiting for a clock edge. Each clock edge that sees the break also sets a sticky status flag. An interrupt request follows the flag when its enable is set.

After the fault goes away, the enable can come back in two ways. Software can write a 1 to it, or the controller can set it again on the next timer update event when automatic re-enable is configured. Neither path works while the break is still present.

A configuration register file holds the settings that protect the output stage: dead time, break enable and polarity, per-channel idle levels, polarities and output modes, and the off-state select. A lock level can be written once after reset. Levels 1 to 3 freeze progressively larger groups of these settings. The block has no streaming data path: every pin is a plain level or a single-cycle strobe, and there is no valid/ready handshake or back-pressure.

Top module: `brkctl_top`

## Requirements
- R1: The break condition is `cfg_brk_en_q && (brk_pin == cfg_brk_pol_q)`. A polarity of 1 means active high and 0 means active low. With the enable bit at 0 the pin has no effect on `moe` or `brk_flag`.
- R2: While the break condition holds, `moe` is 0 within the same cycle, without waiting for a clock edge.
- R3: A pulse on `sw_moe_set` sets `moe` to 1 at the next clock edge, and a pulse on `sw_moe_clr` clears it. When both pulse together, the clear wins.
- R4: With `cfg_auto_q` = 1, a pulse on `upd_evt` sets `moe` at that edge. With `cfg_auto_q` = 0, an update event leaves `moe` unchanged.
- R5: While the break condition holds, neither a software set nor an update event sets `moe`, including an update event in the same cycle in which the break arrives.
- R6: Each clock edge with the break condition present sets `brk_flag`. `brk_irq` equals `brk_flag` AND `brk_ie`.
- R7: A pulse on `sw_flag_clr` clears `brk_flag` only when no break condition is present at that edge. Otherwise the pulse is ignored.
- R8: `moe_rd` is a copy of `moe` delayed by exactly one clock cycle.
- R9: `lock_wr` takes effect only the first time it pulses after reset. `lock_lvl` takes `lock_in` at that edge, and every later write is ignored.
- R10: Lock level 0 freezes nothing. Level 1 freezes dead time, break enable, break polarity and idle levels. Level 2 also freezes output polarities and off-state select. Level 3 also freezes output modes. A `cfg_wr` pulse updates only fields that are not frozen; frozen fields ignore it silently. `cfg_auto_q` is never frozen. A `cfg_wr` in the same cycle as the first `lock_wr` is judged against the old lock level.
- R11: `out_en_hold` is `moe` OR `cfg_off_sel_q`. It tells the output stage to keep its enables driven while the main enable is low.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_pin | input | 1 | Raw break (fault) pin |
| upd_evt | input | 1 | Timer update-event strobe |
| sw_moe_set | input | 1 | Software writes 1 to main enable |
| sw_moe_clr | input | 1 | Software writes 0 to main enable |
| sw_flag_clr | input | 1 | Software writes 0 to break flag |
| brk_ie | input | 1 | Break interrupt enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dead_in | input | DT_W | Dead-time value to write |
| cfg_idle_in | input | CH | Per-channel idle levels to write |
| cfg_pol_in | input | CH | Per-channel output polarities to write |
| cfg_mode_in | input | CH*MODE_W | Per-channel output modes to write |
| cfg_brk_en_in | input | 1 | Break enable to write |
| cfg_brk_pol_in | input | 1 | Break polarity to write |
| cfg_auto_in | input | 1 | Automatic re-enable to write |
| cfg_off_sel_in | input | 1 | Off-state select to write |
| lock_wr | input | 1 | Lock level write strobe |
| lock_in | input | 2 | Lock level to write |
| moe | output | 1 | Main output enable |
| moe_rd | output | 1 | Resynchronized read copy of main enable |
| out_en_hold | output | 1 | Keep output enables driven while off |
| brk_flag | output | 1 | Sticky break status flag |
| brk_irq | output | 1 | Break interrupt request |
| lock_lvl | output | 2 | Current lock level |
| cfg_dead_q | output | DT_W | Dead time held |
| cfg_idle_q | output | CH | Idle levels held |
| cfg_pol_q | output | CH | Output polarities held |
| cfg_mode_q | output | CH*MODE_W | Output modes held |
| cfg_brk_en_q | output | 1 | Break enable held |
| cfg_brk_pol_q | output | 1 | Break polarity held |
| cfg_auto_q | output | 1 | Automatic re-enable held |
| cfg_off_sel_q | output | 1 | Off-state select held |

## Verification
Three results are combinational with respect to their inputs: the drop of `moe` on a break, `brk_irq` and `out_en_hold`. The bench samples these one nanosecond after it drives the stimulus. Every other result is registered once. The bench drives a strobe on a falling edge, lets one rising edge pass, and samples at the following falling edge. `moe_rd` adds one more register, so the bench checks it both at that falling edge, where it still shows the old value, and one cycle later. The sweeps cover every enable/polarity/pin combination and every lock level, with a fresh reset for each level, and derive the expected value of each field from the requirement tables.

// File: rtl/brkctl_pkg.sv
package brkctl_pkg;
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_L1   = 2'd1,
    LK_L2   = 2'd2,
    LK_L3   = 2'd3
  } lock_e;
endpackage

// File: rtl/brkctl_detect.sv
// Gates and polarity-matches the raw fault pin.
module brkctl_detect (
  input  logic pin,
  input  logic en,
  input  logic pol,
  output logic act
);
  always_comb act = en & ~(pin ^ pol);
endmodule

// File: rtl/brkctl_moe.sv
// Main enable state: break has priority, then clear, then set, then auto.
module brkctl_moe (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic upd,
  input  logic auto_en,
  output logic moe,
  output logic moe_rd
);
  logic moe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moe_q  <= 1'b0;
      moe_rd <= 1'b0;
    end else begin
      if (act)                 moe_q <= 1'b0;
      else if (sw_clr)         moe_q <= 1'b0;
      else if (sw_set)         moe_q <= 1'b1;
      else if (upd && auto_en) moe_q <= 1'b1;
      moe_rd <= moe;
    end
  end

  // combinational kill path: no clock needed to drop the enable
  always_comb moe = moe_q & ~act;
endmodule

// File: rtl/brkctl_flag.sv
// Sticky break flag; clear is refused while the fault persists.
module brkctl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (act)  flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

  always_comb irq = flag & ie;
endmodule

// File: rtl/brkctl_cfg.sv
// Protection settings with a once-only, three-level lock.
module brkctl_cfg
  import brkctl_pkg::*;
#(
  parameter int CH     = 2,
  parameter int DT_W   = 8,
  parameter int MODE_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [DT_W-1:0]      dead_in,
  input  logic [CH-1:0]        idle_in,
  input  logic [CH-1:0]        pol_in,
  input  logic [CH*MODE_W-1:0] mode_in,
  input  logic                 brk_en_in,
  input  logic                 brk_pol_in,
  input  logic                 auto_in,
  input  logic                 off_sel_in,
  input  logic                 lock_wr,
  input  logic [1:0]           lock_in,
  output logic [1:0]           lock_lvl,
  output logic [DT_W-1:0]      dead_q,
  output logic [CH-1:0]        idle_q,
  output logic [CH-1:0]        pol_q,
  output logic [CH*MODE_W-1:0] mode_q,
  output logic                 brk_en_q,
  output logic                 brk_pol_q,
  output logic                 auto_q,
  output logic                 off_sel_q
);
  lock_e lock_q;
  logic  lock_done;
  logic  wr_g1, wr_g2, wr_g3;

  always_comb begin
    wr_g1 = cfg_wr && (lock_q < LK_L1);
    wr_g2 = cfg_wr && (lock_q < LK_L2);
    wr_g3 = cfg_wr && (lock_q < LK_L3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= LK_NONE;
      lock_done <= 1'b0;
      dead_q    <= '0;
      brk_en_q  <= 1'b0;
      brk_pol_q <= 1'b0;
      off_sel_q <= 1'b0;
      auto_q    <= 1'b0;
    end else begin
      if (lock_wr && !lock_done) begin
        lock_q    <= lock_e'(lock_in);
        lock_done <= 1'b1;
      end
      if (wr_g1) begin
        dead_q    <= dead_in;
        brk_en_q  <= brk_en_in;
        brk_pol_q <= brk_pol_in;
      end
      if (wr_g2)  off_sel_q <= off_sel_in;
      if (cfg_wr) auto_q    <= auto_in;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idle_q[c]                  <= 1'b0;
        pol_q[c]                   <= 1'b0;
        mode_q[c*MODE_W +: MODE_W] <= '0;
      end else begin
        if (wr_g1) idle_q[c] <= idle_in[c];
        if (wr_g2) pol_q[c]  <= pol_in[c];
        if (wr_g3) mode_q[c*MODE_W +: MODE_W] <= mode_in[c*MODE_W +: MODE_W];
      end
    end
  end

  always_comb lock_lvl = lock_q;
endmodule

// File: rtl/brkctl_top.sv
module brkctl_top #(
  parameter int CH     = 2,
  parameter int DT_W   = 8,
  parameter int MODE_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 brk_pin,
  input  logic                 upd_evt,
  input  logic                 sw_moe_set,
  input  logic                 sw_moe_clr,
  input  logic                 sw_flag_clr,
  input  logic                 brk_ie,
  input  logic                 cfg_wr,
  input  logic [DT_W-1:0]      cfg_dead_in,
  input  logic [CH-1:0]        cfg_idle_in,
  input  logic [CH-1:0]        cfg_pol_in,
  input  logic [CH*MODE_W-1:0] cfg_mode_in,
  input  logic                 cfg_brk_en_in,
  input  logic                 cfg_brk_pol_in,
  input  logic                 cfg_auto_in,
  input  logic                 cfg_off_sel_in,
  input  logic                 lock_wr,
  input  logic [1:0]           lock_in,
  output logic                 moe,
  output logic                 moe_rd,
  output logic                 out_en_hold,
  output logic                 brk_flag,
  output logic                 brk_irq,
  output logic [1:0]           lock_lvl,
  output logic [DT_W-1:0]      cfg_dead_q,
  output logic [CH-1:0]        cfg_idle_q,
  output logic [CH-1:0]        cfg_pol_q,
  output logic [CH*MODE_W-1:0] cfg_mode_q,
  output logic                 cfg_brk_en_q,
  output logic                 cfg_brk_pol_q,
  output logic                 cfg_auto_q,
  output logic                 cfg_off_sel_q
);
  logic brk_act;

  brkctl_detect u_det (
    .pin (brk_pin),
    .en  (cfg_brk_en_q),
    .pol (cfg_brk_pol_q),
    .act (brk_act)
  );

  brkctl_moe u_moe (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (brk_act),
    .sw_set  (sw_moe_set),
    .sw_clr  (sw_moe_clr),
    .upd     (upd_evt),
    .auto_en (cfg_auto_q),
    .moe     (moe),
    .moe_rd  (moe_rd)
  );

  brkctl_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (brk_act),
    .clr   (sw_flag_clr),
    .ie    (brk_ie),
    .flag  (brk_flag),
    .irq   (brk_irq)
  );

  brkctl_cfg #(.CH(CH), .DT_W(DT_W), .MODE_W(MODE_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .dead_in    (cfg_dead_in),
    .idle_in    (cfg_idle_in),
    .pol_in     (cfg_pol_in),
    .mode_in    (cfg_mode_in),
    .brk_en_in  (cfg_brk_en_in),
    .brk_pol_in (cfg_brk_pol_in),
    .auto_in    (cfg_auto_in),
    .off_sel_in (cfg_off_sel_in),
    .lock_wr    (lock_wr),
    .lock_in    (lock_in),
    .lock_lvl   (lock_lvl),
    .dead_q     (cfg_dead_q),
    .idle_q     (cfg_idle_q),
    .pol_q      (cfg_pol_q),
    .mode_q     (cfg_mode_q),
    .brk_en_q   (cfg_brk_en_q),
    .brk_pol_q  (cfg_brk_pol_q),
    .auto_q     (cfg_auto_q),
    .off_sel_q  (cfg_off_sel_q)
  );

  always_comb out_en_hold = moe | cfg_off_sel_q;
endmodule

// File: rtl/brkctl_chk.sv
module brkctl_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            brk_pin,
  input logic            brk_ie,
  input logic            moe,
  input logic            moe_rd,
  input logic            brk_flag,
  input logic            brk_irq,
  input logic [1:0]      lock_lvl,
  input logic [DT_W-1:0] cfg_dead_q,
  input logic            cfg_brk_en_q,
  input logic            cfg_brk_pol_q
);
  logic fault;
  always_comb fault = cfg_brk_en_q && (brk_pin == cfg_brk_pol_q);

  AST_BRK_KILLS_MOE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !moe); // R2
  AST_NO_SET_IN_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !moe); // R5
  AST_FLAG_ON_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> brk_flag); // R6
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_ie |-> !brk_irq); // R6
  AST_RD_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    moe_rd == $past(moe)); // R8
  AST_LOCK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lvl != 2'd0) |=> $stable(lock_lvl)); // R9
  AST_DEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lvl != 2'd0) |=> $stable(cfg_dead_q)); // R10
endmodule

bind brkctl_top brkctl_chk #(.DT_W(DT_W)) u_chk (.*);

// File: tb/brkctl_top_bench.sv
module brkctl_top_bench;
  localparam int CH = 2, DT_W = 8, MODE_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic brk_pin = 0, upd_evt = 0, sw_moe_set = 0, sw_moe_clr = 0, sw_flag_clr = 0;
  logic brk_ie = 0, cfg_wr = 0, lock_wr = 0;
  logic [DT_W-1:0] cfg_dead_in = '0;
  logic [CH-1:0] cfg_idle_in = '0, cfg_pol_in = '0;
  logic [CH*MODE_W-1:0] cfg_mode_in = '0;
  logic cfg_brk_en_in = 0, cfg_brk_pol_in = 0, cfg_auto_in = 0, cfg_off_sel_in = 0;
  logic [1:0] lock_in = '0;
  logic moe, moe_rd, out_en_hold, brk_flag, brk_irq;
  logic [1:0] lock_lvl;
  logic [DT_W-1:0] cfg_dead_q;
  logic [CH-1:0] cfg_idle_q, cfg_pol_q;
  logic [CH*MODE_W-1:0] cfg_mode_q;
  logic cfg_brk_en_q, cfg_brk_pol_q, cfg_auto_q, cfg_off_sel_q;

  int n_chk = 0, n_fail = 0;

  brkctl_top #(.CH(CH), .DT_W(DT_W), .MODE_W(MODE_W)) u_brkctl_top (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #25;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic en, input logic pol, input logic auto_v, input logic off_v);
    cfg_brk_en_in = en; cfg_brk_pol_in = pol; cfg_auto_in = auto_v; cfg_off_sel_in = off_v;
    cfg_wr = 1; step(); cfg_wr = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R12: reset state
    chk("R12 moe", moe, 0);
    chk("R12 moe_rd", moe_rd, 0);
    chk("R12 flag", brk_flag, 0);
    chk("R12 irq", brk_irq, 0);
    chk("R12 lock", lock_lvl, 0);
    chk("R12 dead", cfg_dead_q, 0);
    chk("R12 hold", out_en_hold, 0);

    // R1/R2/R6: sweep enable x polarity x pin level
    brk_ie = 1;
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++)
        for (int v = 0; v < 2; v++) begin
          brk_pin = ~p[0];
          write_cfg(e[0], p[0], 1'b0, 1'b0);
          sw_flag_clr = 1; step(); sw_flag_clr = 0;
          sw_moe_set = 1; step(); sw_moe_set = 0;
          chk("R3 set", moe, 1);
          brk_pin = v[0];
          #1;
          chk("R1 R2 moe on pin", moe, (e == 1 && v == p) ? 0 : 1);
          step();
          chk("R1 R6 flag", brk_flag, (e == 1 && v == p) ? 1 : 0);
          chk("R6 irq", brk_irq, (e == 1 && v == p) ? 1 : 0);
          brk_pin = ~p[0];
          step();
        end

    // R5/R7: break held active-high with auto re-enable
    sw_flag_clr = 1; step(); sw_flag_clr = 0;
    write_cfg(1'b1, 1'b1, 1'b1, 1'b0);
    sw_moe_set = 1; step(); sw_moe_set = 0;
    brk_pin = 1; upd_evt = 1; step(); upd_evt = 0;
    chk("R5 brk with upd same cycle", moe, 0);
    sw_moe_set = 1; step(); sw_moe_set = 0;
    chk("R5 sw set during brk", moe, 0);
    upd_evt = 1; step(); upd_evt = 0;
    chk("R5 upd during brk", moe, 0);
    sw_flag_clr = 1; step(); sw_flag_clr = 0;
    chk("R7 clr ignored in brk", brk_flag, 1);
    brk_ie = 0; #1;
    chk("R6 irq masked", brk_irq, 0);
    brk_ie = 1;
    brk_pin = 0; step();
    chk("R7 flag held after release", brk_flag, 1);
    sw_flag_clr = 1; step(); sw_flag_clr = 0;
    chk("R7 clr works", brk_flag, 0);

    // R4/R8: automatic re-enable and read lag
    upd_evt = 1; step(); upd_evt = 0;
    chk("R4 auto upd sets", moe, 1);
    chk("R8 rd lags", moe_rd, 0);
    step();
    chk("R8 rd follows", moe_rd, 1);
    sw_moe_clr = 1; step(); sw_moe_clr = 0;
    chk("R3 clr", moe, 0);
    write_cfg(1'b1, 1'b1, 1'b0, 1'b0);
    upd_evt = 1; step(); upd_evt = 0;
    chk("R4 no auto", moe, 0);
    sw_moe_set = 1; sw_moe_clr = 1; step(); sw_moe_set = 0; sw_moe_clr = 0;
    chk("R3 clr wins", moe, 0);

    // R11: off-state select holds enables
    write_cfg(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R11 hold with off_sel", out_en_hold, 1);
    write_cfg(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R11 no hold", out_en_hold, 0);

    // R9/R10: lock levels, fresh reset for each
    for (int l = 0; l < 4; l++) begin
      do_reset();
      lock_in = l[1:0]; lock_wr = 1; step(); lock_wr = 0;
      chk("R9 lock taken", lock_lvl, l);
      cfg_dead_in = '1; cfg_idle_in = '1; cfg_pol_in = '1; cfg_mode_in = '1;
      cfg_brk_pol_in = 1; cfg_brk_en_in = 0; cfg_auto_in = 1; cfg_off_sel_in = 1;
      cfg_wr = 1; step(); cfg_wr = 0;
      chk("R10 dead", cfg_dead_q, (l < 1) ? 32'hFF : 0);
      chk("R10 idle", cfg_idle_q, (l < 1) ? 32'h3 : 0);
      chk("R10 brk_pol", cfg_brk_pol_q, (l < 1) ? 1 : 0);
      chk("R10 pol", cfg_pol_q, (l < 2) ? 32'h3 : 0);
      chk("R10 off_sel", cfg_off_sel_q, (l < 2) ? 1 : 0);
      chk("R10 mode", cfg_mode_q, (l < 3) ? 32'h3F : 0);
      chk("R10 auto never frozen", cfg_auto_q, 1);
      lock_in = ~l[1:0]; lock_wr = 1; step(); lock_wr = 0;
      chk("R9 second write ignored", lock_lvl, l);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule